// File: doc/BRIEF.md
# Dual-Direction Latched Bus Transceiver

This block is a 16-bit bidirectional transceiver with a data latch in each direction. It is split into two independent 8-bit sections. Each section has an A-to-B path and a B-to-A path. Each path has three active-low controls: a chip enable, a latch enable and an output enable.

A path copies its input side into its latch while the chip enable and the latch enable are both low. When the latch enable goes high, the latch keeps the last value it took. A path drives its output side only while its chip enable and its output enable are both low. The driven value is the live input while the latch is transparent, and the stored value otherwise.

Each pad group is presented as separate input, output and output-enable vectors, so an enclosing wrapper can build the tri-state pads. The latch is a clocked capture register. It takes the input at every rising clock edge on which the path is transparent. The value that a storage phase holds is therefore the input seen at the last such edge.

Top module: `latched_xcvr`

## Requirements
- R1: After the synchronous active-high reset, every latch holds zero, so a path with chip enable low, latch enable high and output enable low drives all zeros.
- R2: With chip enable low, latch enable low and output enable low, the output side equals the live input side in the same cycle, and the latch captures that input at each rising clock edge.
- R3: With chip enable low and latch enable high, the latch keeps the value captured at the last rising edge on which it was transparent, across any number of input changes, and a driven output presents that value.
- R4: With chip enable high, the path neither captures nor drives, whatever its latch enable and output enable are; its output-enable bits are 0 and its output data is 0, and the earlier stored value is still there once chip enable returns low.
- R5: With output enable high and chip enable low, the output is not driven (output-enable bits 0, data 0), while the latch still follows the transparency rule of R2 and R3.
- R6: The B-to-A path obeys R2 to R5 using its own three controls, with b_in as the input and a_out/a_oe as the output, independently of the A-to-B path of the same section.
- R7: Section 1 (bits 15..8, control index 1) behaves independently of section 0 (bits 7..0, control index 0).
- R8: Within one section and one direction, the eight output-enable bits are all equal, and every output data bit whose enable is 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for latch capture |
| rst | input | 1 | Synchronous active-high reset, clears all latches |
| ce_ab_n | input | 2 | A-to-B chip enable per section, active low |
| le_ab_n | input | 2 | A-to-B latch enable per section, active low |
| oe_ab_n | input | 2 | A-to-B output enable per section, active low |
| ce_ba_n | input | 2 | B-to-A chip enable per section, active low |
| le_ba_n | input | 2 | B-to-A latch enable per section, active low |
| oe_ba_n | input | 2 | B-to-A output enable per section, active low |
| a_in | input | 16 | Data arriving on the A pads |
| a_out | output | 16 | Data the block drives onto the A pads |
| a_oe | output | 16 | Per-bit drive enable for the A pads |
| b_in | input | 16 | Data arriving on the B pads |
| b_out | output | 16 | Data the block drives onto the B pads |
| b_oe | output | 16 | Per-bit drive enable for the B pads |

## Verification
The bench changes the inputs many times while a latch is in storage and checks that the output keeps the captured value. A design that still followed the input, or that captured at the wrong edge, would show the new input instead. It also holds chip enable high while latch enable is low. A design that let latch enable alone open the latch would then present a fresh value when chip enable returned low, and one that let output enable alone drive would raise the enable bits. Random control patterns with both directions of a section active at once expose any crossing of state between directions or sections.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned DEF_SEC_W = 8;
  localparam int unsigned DEF_NSEC  = 2;

  typedef struct packed {
    logic ce_n;
    logic le_n;
    logic oe_n;
  } path_ctl_t;
endpackage

// File: rtl/latch_path.sv
module latch_path #(
  parameter int unsigned W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  xcvr_pkg::path_ctl_t  ctl,
  input  logic [W-1:0]         d_in,
  output logic [W-1:0]         q_out,
  output logic [W-1:0]         q_oe
);
  logic         transp;
  logic         drive;
  logic [W-1:0] store_q;
  logic [W-1:0] sel_data;

  assign transp = !ctl.ce_n && !ctl.le_n;
  assign drive  = !ctl.ce_n && !ctl.oe_n;

  always_ff @(posedge clk) begin
    if (rst)         store_q <= '0;
    else if (transp) store_q <= d_in;
  end

  always_comb begin
    sel_data = transp ? d_in : store_q;
    q_out    = drive ? sel_data : '0;
    q_oe     = {W{drive}};
  end

  AST_CE_FLOATS: assert property (@(posedge clk) disable iff (rst)
    ctl.ce_n |-> (q_oe == '0 && q_out == '0)); // R4

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (drive && !transp && $past(drive && !transp && !rst)) |-> $stable(q_out)); // R3

  AST_OE_UNIFORM: assert property (@(posedge clk) disable iff (rst)
    ($countones(q_oe) == 0 || $countones(q_oe) == W)); // R8

  AST_OFF_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((q_out & ~q_oe) == '0)); // R8

  AST_CE_NO_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    ($past(ctl.ce_n && !rst) && drive && !transp && $past(!rst)) |-> (q_out == $past(store_q))); // R4
endmodule

// File: rtl/xcvr_section.sv
module xcvr_section #(
  parameter int unsigned W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  xcvr_pkg::path_ctl_t ctl_ab,
  input  xcvr_pkg::path_ctl_t ctl_ba,
  input  logic [W-1:0]        a_in,
  input  logic [W-1:0]        b_in,
  output logic [W-1:0]        a_out,
  output logic [W-1:0]        a_oe,
  output logic [W-1:0]        b_out,
  output logic [W-1:0]        b_oe
);
  latch_path #(.W(W)) u_ab (
    .clk(clk), .rst(rst), .ctl(ctl_ab),
    .d_in(a_in), .q_out(b_out), .q_oe(b_oe)
  );

  latch_path #(.W(W)) u_ba (
    .clk(clk), .rst(rst), .ctl(ctl_ba),
    .d_in(b_in), .q_out(a_out), .q_oe(a_oe)
  );
endmodule

// File: rtl/latched_xcvr.sv
module latched_xcvr #(
  parameter int unsigned SEC_W = xcvr_pkg::DEF_SEC_W,
  parameter int unsigned NSEC  = xcvr_pkg::DEF_NSEC,
  localparam int unsigned BUS_W = SEC_W * NSEC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSEC-1:0]  ce_ab_n,
  input  logic [NSEC-1:0]  le_ab_n,
  input  logic [NSEC-1:0]  oe_ab_n,
  input  logic [NSEC-1:0]  ce_ba_n,
  input  logic [NSEC-1:0]  le_ba_n,
  input  logic [NSEC-1:0]  oe_ba_n,
  input  logic [BUS_W-1:0] a_in,
  output logic [BUS_W-1:0] a_out,
  output logic [BUS_W-1:0] a_oe,
  input  logic [BUS_W-1:0] b_in,
  output logic [BUS_W-1:0] b_out,
  output logic [BUS_W-1:0] b_oe
);
  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    xcvr_pkg::path_ctl_t ctl_ab;
    xcvr_pkg::path_ctl_t ctl_ba;
    assign ctl_ab = '{ce_n: ce_ab_n[s], le_n: le_ab_n[s], oe_n: oe_ab_n[s]};
    assign ctl_ba = '{ce_n: ce_ba_n[s], le_n: le_ba_n[s], oe_n: oe_ba_n[s]};

    xcvr_section #(.W(SEC_W)) u_sec (
      .clk(clk), .rst(rst),
      .ctl_ab(ctl_ab), .ctl_ba(ctl_ba),
      .a_in (a_in [s*SEC_W +: SEC_W]),
      .b_in (b_in [s*SEC_W +: SEC_W]),
      .a_out(a_out[s*SEC_W +: SEC_W]),
      .a_oe (a_oe [s*SEC_W +: SEC_W]),
      .b_out(b_out[s*SEC_W +: SEC_W]),
      .b_oe (b_oe [s*SEC_W +: SEC_W])
    );
  end
endmodule

// File: tb/latched_xcvr_bench.sv
`timescale 1ns/1ps
module latched_xcvr_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  ce_ab_n = '1, le_ab_n = '1, oe_ab_n = '1;
  logic [1:0]  ce_ba_n = '1, le_ba_n = '1, oe_ba_n = '1;
  logic [15:0] a_in = '0, b_in = '0;
  logic [15:0] a_out, a_oe, b_out, b_oe;

  int unsigned errors = 0;
  int unsigned checks = 0;
  logic [7:0]  m_ab [2];
  logic [7:0]  m_ba [2];

  always #5 clk = ~clk;

  latched_xcvr u_latched_xcvr (
    .clk(clk), .rst(rst),
    .ce_ab_n(ce_ab_n), .le_ab_n(le_ab_n), .oe_ab_n(oe_ab_n),
    .ce_ba_n(ce_ba_n), .le_ba_n(le_ba_n), .oe_ba_n(oe_ba_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  function automatic logic [7:0] exp_data(logic ce, logic le, logic oe,
                                          logic [7:0] din, logic [7:0] st);
    if (ce || oe) return 8'h00;
    return le ? st : din;
  endfunction

  function automatic string cls(logic ce, logic le, logic oe);
    if (ce) return "R4";
    if (oe) return "R5";
    return le ? "R3" : "R2";
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] cab, lab, oab, cba, lba, oba,
                       input logic [15:0] a, b, input string over);
    string t;
    @(negedge clk);
    ce_ab_n = cab; le_ab_n = lab; oe_ab_n = oab;
    ce_ba_n = cba; le_ba_n = lba; oe_ba_n = oba;
    a_in = a; b_in = b;
    #1;
    for (int s = 0; s < 2; s++) begin
      t = (over != "") ? over : cls(cab[s], lab[s], oab[s]);
      if (s == 1) t = {"R7 ", t};
      chk({t, " b_out"}, b_out[s*8 +: 8],
          exp_data(cab[s], lab[s], oab[s], a[s*8 +: 8], m_ab[s]));
      chk({"R8 ", t, " b_oe"}, b_oe[s*8 +: 8], {8{!cab[s] && !oab[s]}});
      t = (over != "") ? over : cls(cba[s], lba[s], oba[s]);
      t = {"R6 ", t};
      if (s == 1) t = {"R7 ", t};
      chk({t, " a_out"}, a_out[s*8 +: 8],
          exp_data(cba[s], lba[s], oba[s], b[s*8 +: 8], m_ba[s]));
      chk({"R8 ", t, " a_oe"}, a_oe[s*8 +: 8], {8{!cba[s] && !oba[s]}});
    end
    @(posedge clk);
    for (int s = 0; s < 2; s++) begin
      if (!cab[s] && !lab[s]) m_ab[s] = a[s*8 +: 8];
      if (!cba[s] && !lba[s]) m_ba[s] = b[s*8 +: 8];
    end
  endtask

  function automatic logic [1:0] rbit2();
    logic [1:0] r;
    r[0] = (($urandom % 10) < 3);
    r[1] = (($urandom % 10) < 3);
    return r;
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int s = 0; s < 2; s++) begin m_ab[s] = 8'h00; m_ba[s] = 8'h00; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1: reset contents visible in storage mode
    apply(2'b00, 2'b11, 2'b00, 2'b00, 2'b11, 2'b00, 16'hFFFF, 16'hFFFF, "R1");

    // R2: transparent load, both directions
    apply(2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 16'hC35A, 16'h96A5, "R2");
    // R3: storage across several input changes
    for (int i = 0; i < 5; i++)
      apply(2'b00, 2'b11, 2'b00, 2'b00, 2'b11, 2'b00,
            16'(i * 16'h1111), 16'(~(i * 16'h0F0F)), "R3");
    // R4: chip enable high with latch enable low: no capture, no drive
    for (int i = 0; i < 3; i++)
      apply(2'b11, 2'b00, 2'b00, 2'b11, 2'b00, 2'b00, 16'h0F0F + 16'(i), 16'h7E7E, "R4");
    // R4: old value still held afterwards
    apply(2'b00, 2'b11, 2'b00, 2'b00, 2'b11, 2'b00, 16'h1234, 16'h4321, "R4");
    // R5: output disabled while loading, then stored value appears
    apply(2'b00, 2'b00, 2'b11, 2'b00, 2'b00, 2'b11, 16'hA1B2, 16'hC3D4, "R5");
    apply(2'b00, 2'b11, 2'b00, 2'b00, 2'b11, 2'b00, 16'h0000, 16'h0000, "R5");
    // R7: section 0 loads, section 1 holds
    apply(2'b10, 2'b10, 2'b00, 2'b10, 2'b10, 2'b00, 16'h55AA, 16'h33CC, "");
    apply(2'b00, 2'b11, 2'b00, 2'b00, 2'b11, 2'b00, 16'h0000, 16'h0000, "");

    // random mix, both directions active together
    for (int i = 0; i < 400; i++)
      apply(rbit2(), rbit2(), rbit2(), rbit2(), rbit2(), rbit2(),
            16'($urandom), 16'($urandom), "");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule